// File: doc/BRIEF.md
# Round-Robin Arbiter with Priority Override and Grant Delay

This block shares one resource among four requesters. Each requester raises its bit of a request vector and holds it for as long as it needs the resource. The arbiter answers with a grant vector that has at most one bit set. Requesters are normally served in circular order from a rotating pointer, so each gets an equal turn and none starves. A configuration mask can mark any requester as a priority master. Priority masters win over the circular order, and among several of them the lowest index wins.

A programmable wait count sets how many extra clocks pass between the moment a request is taken and the moment its grant appears. With a count of zero, a request that arrives while the arbiter is idle is granted on the very next clock.

The control is a three-state machine:
- IDLE: arbitrates among the current requests.
- WAIT: counts down the programmed delay.
- GRANT: holds the grant until the served request drops.

The transitions are:
- IDLE→GRANT: any request is present and the delay is zero.
- IDLE→WAIT: any request is present and the delay is non-zero.
- WAIT→GRANT: the countdown has expired and the chosen request is still high.
- WAIT→IDLE: the chosen request drops during the countdown. This is an abandon.
- GRANT→IDLE: the served request drops. This is a release.
- Otherwise the machine stays in its current state.

Top module: `rr_prio_arbiter`

## Requirements
- R1: The grant vector `gnt_o` is always either all zero or exactly one-hot.
- R2: When no priority master is requesting, the arbiter searches `req_i` upward from the round-robin pointer, wrapping from index 3 to index 0, and picks the first request it finds.
- R3: With `delay_i` = 0, a request seen while the arbiter is idle is granted at the next rising clock edge.
- R4: A requester whose bit in `prio_i` is 1 and which is requesting wins over every non-priority requester. Among several such requesters, the lowest index wins.
- R5: With `delay_i` = D > 0, the grant appears D clocks later than it would with a delay of zero. If the chosen request drops during that wait, no grant is given and the arbiter returns to IDLE.
- R6: Releasing a grant that was won through round-robin moves the pointer to the served index plus one, modulo 4. Releasing a grant that was won through priority leaves the pointer unchanged.
- R7: A grant stays asserted, unchanged, while its request stays high.
- R8: The edge that samples the served request low clears the grant. The next grant can appear no earlier than one clock after that.
- R9: A synchronous active-high `rst` clears the grant, sets the pointer to 0 and puts the machine in IDLE.
- R10: A grant bit is only ever set for a requester whose request was high at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Request vector, one bit per requester |
| prio_i | input | 4 | Priority-master mask, 1 marks a requester as priority |
| delay_i | input | 4 | Extra request-to-grant wait in clocks, 0 for none |
| gnt_o | output | 4 | Grant vector, zero or one-hot |

## Verification
The bench targets the following corner cases. Pointer wrap from requester 3 back to 0 is checked because an arbiter without the modulo would stall or grant a non-existent requester. A priority grant is followed by a round-robin grant to show the pointer did not move; a design that advanced it there would skip a requester. Several priority masters request together, and a design that resolved them from the pointer would pick the wrong one. The bench checks that a request dropped mid-countdown is abandoned rather than granted. It also checks the exact delay count, since an off-by-one timer shifts the grant by one clock. A random phase with changing masks and delays is compared every clock against a behavioural model.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_GRANT = 2'd2
    } arb_state_e;
endpackage

// File: rtl/rr_pick.sv
// Combinational winner selection: priority masters first (lowest index),
// otherwise first request found searching upward from the pointer.
module rr_pick #(
    parameter int N  = 4,
    parameter int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  prio,
    input  logic [PW-1:0] ptr,
    output logic [PW-1:0] win,
    output logic          by_prio,
    output logic          any
);
    always_comb begin
        int idx;
        win     = '0;
        by_prio = 1'b0;
        any     = |req;
        idx     = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && prio[i]) begin
                win     = PW'(i);
                by_prio = 1'b1;
            end
        end
        if (!by_prio) begin
            for (int k = N - 1; k >= 0; k--) begin
                idx = (int'(ptr) + k) % N;
                if (req[idx]) begin
                    win = PW'(idx);
                end
            end
        end
    end
endmodule

// File: rtl/arb_wait_timer.sv
// Down-counter for the request-to-grant delay.
module arb_wait_timer #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - DW'(1);
        end
    end

    assign last = (cnt == DW'(1));
endmodule

// File: rtl/rr_prio_arbiter.sv
module rr_prio_arbiter
    import rr_arb_pkg::*;
#(
    parameter int N     = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req_i,
    input  logic [N-1:0]     prio_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic [N-1:0]     gnt_o
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    arb_state_e    state, nxt;
    logic [PW-1:0] ptr, sel, win;
    logic          sel_prio, by_prio, any;
    logic          take, grant_set, release_gnt, t_load, t_dec, t_last;

    rr_pick #(.N(N), .PW(PW)) u_pick (
        .req(req_i), .prio(prio_i), .ptr(ptr),
        .win(win), .by_prio(by_prio), .any(any)
    );

    arb_wait_timer #(.DW(DLY_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(delay_i),
        .dec(t_dec), .last(t_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Next state and control strobes
    always_comb begin
        nxt         = state;
        take        = 1'b0;
        grant_set   = 1'b0;
        release_gnt = 1'b0;
        t_load      = 1'b0;
        t_dec       = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (any) begin
                    take = 1'b1;
                    if (delay_i == '0) begin
                        nxt       = ST_GRANT;
                        grant_set = 1'b1;
                    end else begin
                        nxt    = ST_WAIT;
                        t_load = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (!req_i[sel]) begin
                    nxt = ST_IDLE;
                end else if (t_last) begin
                    nxt       = ST_GRANT;
                    grant_set = 1'b1;
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_GRANT: begin
                if (!req_i[sel]) begin
                    nxt         = ST_IDLE;
                    release_gnt = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs, selection and pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_o    <= '0;
            ptr      <= '0;
            sel      <= '0;
            sel_prio <= 1'b0;
        end else begin
            if (take) begin
                sel      <= win;
                sel_prio <= by_prio;
            end
            if (grant_set) begin
                gnt_o <= N'(1) << (take ? win : sel);
            end else if (release_gnt) begin
                gnt_o <= '0;
                if (!sel_prio) ptr <= PW'((int'(sel) + 1) % N);
            end
        end
    end

    assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    assert_idle_next_clock_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_i != '0 && delay_i == '0) |=> gnt_o != '0);

    assert_priority_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (req_i & prio_i) != '0 && delay_i == '0)
        |=> (gnt_o & $past(prio_i)) != '0);

    assert_hold_grant_R7: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != '0 && (gnt_o & req_i) != '0) |=> gnt_o == $past(gnt_o));

    assert_release_grant_R8: assert property (@(posedge clk) disable iff (rst)
        (gnt_o != '0 && (gnt_o & req_i) == '0) |=> gnt_o == '0);

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> gnt_o == '0);

    assert_grant_was_requested_R10: assert property (@(posedge clk) disable iff (rst)
        gnt_o != '0 |-> ($past(req_i) & gnt_o) != '0);
endmodule

// File: tb/rr_prio_arbiter_test.sv
`timescale 1ns/1ps
module rr_prio_arbiter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = '0;
    logic [3:0] prio = '0;
    logic [3:0] dly = '0;
    logic [3:0] gnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rr_prio_arbiter uut (
        .clk(clk), .rst(rst), .req_i(req), .prio_i(prio),
        .delay_i(dly), .gnt_o(gnt)
    );

    // Behavioural reference: 0 idle, 1 waiting, 2 granted
    int m_st, m_sel, m_ptr, m_cnt, m_gnt;
    bit m_pri;
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_sel = 0; m_ptr = 0; m_cnt = 0; m_gnt = 0; m_pri = 0;
        end else if (m_st == 0) begin
            if (req != 0) begin
                m_pri = ((req & prio) != 0);
                if (m_pri) begin
                    for (int i = 3; i >= 0; i--) if (req[i] && prio[i]) m_sel = i;
                end else begin
                    for (int k = 0; k < 4; k++)
                        if (req[(m_ptr + k) % 4]) begin m_sel = (m_ptr + k) % 4; break; end
                end
                if (dly == 0) begin m_st = 2; m_gnt = 1 << m_sel; end
                else begin m_st = 1; m_cnt = dly; end
            end
        end else if (m_st == 1) begin
            if (!req[m_sel]) m_st = 0;
            else if (m_cnt == 1) begin m_st = 2; m_gnt = 1 << m_sel; end
            else m_cnt = m_cnt - 1;
        end else begin
            if (!req[m_sel]) begin
                m_st = 0; m_gnt = 0;
                if (!m_pri) m_ptr = (m_sel + 1) % 4;
            end
        end
    end

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) chk("R2 R4 R5 model compare", gnt, m_gnt[3:0]);
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    int hold [4];

    initial begin
        step(2);
        chk("R9 reset grant", gnt, 4'b0000);
        rst = 1'b0;
        step(1);
        chk("R9 idle after reset", gnt, 4'b0000);

        // R3: idle bus, zero delay
        req = 4'b0100; step(1);
        chk("R3 next-clock grant", gnt, 4'b0100);
        step(3);
        chk("R7 grant held", gnt, 4'b0100);
        req = 4'b0000; step(1);
        chk("R8 release", gnt, 4'b0000);

        // R2 / r6_: pointer now 3, wrap to 0
        req = 4'b1011; step(1);
        chk("R2 search from pointer 3", gnt, 4'b1000);
        req = 4'b0011; step(1);
        chk("R8 gap after release", gnt, 4'b0000);
        step(1);
        chk("R2 wrap 3 to 0", gnt, 4'b0001);
        req = 4'b0010; step(1);
        chk("R8 clear", gnt, 4'b0000);
        step(1);
        chk("R6 pointer advanced to 1", gnt, 4'b0010);
        req = 4'b0000; step(1);

        // R4: pointer is 2; priority masters 0 and 3
        prio = 4'b1001; req = 4'b1111; step(1);
        chk("R4 lowest priority master", gnt, 4'b0001);
        req = 4'b1110; step(2);
        chk("R4 remaining priority master", gnt, 4'b1000);
        req = 4'b0110; step(2);
        chk("R6 pointer unmoved by priority", gnt, 4'b0100);
        prio = 4'b0000; req = 4'b0000; step(1);

        // R5: delay of 3
        dly = 4'd3; req = 4'b0001; step(3);
        chk("R5 still waiting", gnt, 4'b0000);
        step(1);
        chk("R5 grant after delay", gnt, 4'b0001);
        req = 4'b0000; step(1);

        // R5: abandon during wait
        dly = 4'd2; req = 4'b0010; step(1);
        req = 4'b0000; step(3);
        chk("R5 abandoned wait", gnt, 4'b0000);
        dly = 4'd0;

        // Random phase, compared each clock against the model (R1, R10)
        for (int i = 0; i < 4; i++) hold[i] = 0;
        for (int c = 0; c < 3000; c++) begin
            if (c % 250 == 0) begin
                prio = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
                dly  = 4'($urandom_range(0, 3));
            end
            if (gnt != 0 && !$onehot(gnt)) chk("R1 one-hot", gnt, 4'b0001);
            for (int i = 0; i < 4; i++) begin
                if (req[i] && gnt[i]) begin
                    hold[i]--;
                    if (hold[i] <= 0) req[i] = 1'b0;
                end else if (!req[i]) begin
                    if ($urandom_range(0, 3) == 0) begin
                        req[i]  = 1'b1;
                        hold[i] = int'($urandom_range(1, 4));
                    end
                end else if ($urandom_range(0, 60) == 0) begin
                    req[i] = 1'b0;
                end
            end
            step(1);
            if ((gnt & ~m_gnt[3:0]) != 0) chk("R10 grant without request", gnt, m_gnt[3:0]);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule